// File: doc/BRIEF.md
# Reverse-Readout Sample Capture Buffer

This block records the samples of a logic analyzer in on-chip block memory and then hands them, one word at a time, to a transmitter through a ready/valid output. Software sets a capture length and issues a start command through a small register port in the style of a Wishbone slave. Once armed, the buffer writes one sample word for every sample-enable pulse, at addresses that count up from zero.

When the set number of samples has been stored, writing stops for good and the same address counter begins to count down. The most recent sample leaves first and the word at address zero leaves last. Sample-enable pulses that arrive after that point are not stored. When the final word has been accepted, the status register shows a done flag and the number of stored samples. A clear command then returns the buffer to idle, ready for the next run.

Top module: `cap_buffer`

## Requirements
- R1: After reset, out_valid and wb_ack_o are low and the status register (address 3) reads 0.
- R2: A bus access is acknowledged by wb_ack_o high exactly one clock after wb_cyc_i and wb_stb_i are both high. The ack lasts one cycle. Read data is valid while ack is high.
- R3: The length register (address 0) stores the written value clamped to DEPTH and reads it back. A start command (any write to address 1) is ignored while the length is 0.
- R4: A start command in idle begins capture, which the status busy bit (bit 1) shows. Each cycle with smp_en high stores smp_data at the next address, counting up from 0.
- R5: After the programmed number of samples, capture ends and no later smp_en pulse is stored.
- R6: Readout presents the stored words newest first, in strictly descending address order, ending at address 0.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged.
- R8: After the word from address 0 is accepted, out_valid falls. Status then shows done (bit 0) = 1, busy = 0, and the stored count in bits 31:16.
- R9: A start command during capture or readout is ignored, and so is a length write made during a run: the run keeps its original length.
- R10: A clear command (any write to address 2) in the done state returns the buffer to idle with status 0. In any other state a clear is ignored.
- R11: With out_ready held high, out_valid stays high with no gap from the first word through the last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Bus write enable |
| wb_adr_i | input | 2 | Register word address |
| wb_dat_i | input | 32 | Bus write data |
| wb_dat_o | output | 32 | Bus read data |
| wb_ack_o | output | 1 | Bus acknowledge |
| smp_en | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Sample word |
| out_data | output | SAMPLE_W | Readout word |
| out_valid | output | 1 | Readout word available |
| out_ready | input | 1 | Transmitter accepts word |

## Verification
The hardest case to reach from the ports is a command that arrives in the middle of a run: a second start or a length change while capture is half done, and a clear during readout. The bench issues these bus writes between two bursts of sample strobes and then checks that the run still ends at its original length. It also keeps strobing samples after capture has ended, while the transmitter stalls. Then, on readout, it checks that only the first words came back, in reverse order.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_CAPTURE = 2'd1,
    ST_READOUT = 2'd2,
    ST_DONE    = 2'd3
  } cap_state_e;

  localparam logic [1:0] REG_LEN    = 2'd0;
  localparam logic [1:0] REG_START  = 2'd1;
  localparam logic [1:0] REG_CLEAR  = 2'd2;
  localparam logic [1:0] REG_STATUS = 2'd3;
endpackage

// File: rtl/cap_mem.sv
module cap_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/cap_regs.sv
module cap_regs
  import cap_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc,
  input  logic             stb,
  input  logic             we,
  input  logic [1:0]       adr,
  input  logic [31:0]      wdat,
  output logic [31:0]      rdat,
  output logic             ack,
  input  cap_state_e       state,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] len,
  output logic             start_cmd,
  output logic             clear_cmd
);
  logic access;
  logic wr;
  logic [31:0] status_word;

  assign access    = cyc && stb && !ack;
  assign wr        = access && we;
  assign start_cmd = wr && (adr == REG_START);
  assign clear_cmd = wr && (adr == REG_CLEAR);

  always_comb begin
    status_word        = '0;
    status_word[0]     = (state == ST_DONE);
    status_word[1]     = (state == ST_CAPTURE) || (state == ST_READOUT);
    status_word[16 +: CNT_W] = count;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack  <= 1'b0;
      rdat <= '0;
      len  <= '0;
    end else begin
      ack <= access;
      if (access) begin
        case (adr)
          REG_LEN:    rdat <= 32'(len);
          REG_STATUS: rdat <= status_word;
          default:    rdat <= '0;
        endcase
      end
      if (wr && adr == REG_LEN) begin
        if (wdat > 32'(DEPTH)) len <= CNT_W'(DEPTH);
        else                   len <= CNT_W'(wdat);
      end
    end
  end

  a_r2_ack_follows: assert property (@(posedge clk) disable iff (rst)
    (cyc && stb && !ack) |=> ack);
  a_r2_ack_single: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);
  a_r3_len_bound: assert property (@(posedge clk) disable iff (rst)
    32'(len) <= 32'(DEPTH));
endmodule

// File: rtl/cap_seq.sv
module cap_seq
  import cap_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_cmd,
  input  logic              clear_cmd,
  input  logic [CNT_W-1:0]  len,
  input  logic              smp_en,
  input  logic              out_ready,
  output cap_state_e        state,
  output logic [CNT_W-1:0]  count,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic              out_valid
);
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  len_run;
  logic              last_word;
  logic              accept;

  assign last_word = (addr == '0);
  assign accept    = out_valid && out_ready;
  assign mem_we    = (state == ST_CAPTURE) && smp_en;
  assign mem_waddr = addr;
  // Fetch the first word on entry; afterwards prefetch the next lower address on each accept.
  assign mem_re    = (state == ST_READOUT) && (!out_valid || (out_ready && !last_word));
  assign mem_raddr = out_valid ? ADDR_W'(addr - 1'b1) : addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      addr      <= '0;
      count     <= '0;
      len_run   <= '0;
      out_valid <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_cmd && len != '0) begin
            state   <= ST_CAPTURE;
            addr    <= '0;
            count   <= '0;
            len_run <= len;
          end
        end
        ST_CAPTURE: begin
          if (smp_en) begin
            count <= count + 1'b1;
            if ((count + CNT_W'(1)) == len_run) state <= ST_READOUT;
            else                                addr  <= addr + 1'b1;
          end
        end
        ST_READOUT: begin
          if (!out_valid) begin
            out_valid <= 1'b1;
          end else if (out_ready) begin
            if (last_word) begin
              out_valid <= 1'b0;
              state     <= ST_DONE;
            end else begin
              addr <= addr - 1'b1;
            end
          end
        end
        ST_DONE: begin
          if (clear_cmd) begin
            state <= ST_IDLE;
            count <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r7_valid_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid);
  a_r8_end_after_zero: assert property (@(posedge clk) disable iff (rst)
    (accept && last_word) |=> (state == ST_DONE) && !out_valid);
  a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_CAPTURE || state == ST_READOUT) && start_cmd) |=> state != ST_IDLE);
  a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CAPTURE) |-> (count < len_run));
  a_r11_valid_in_readout: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (state == ST_READOUT));
endmodule

// File: rtl/cap_buffer.sv
module cap_buffer
  import cap_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int DEPTH    = 256,
  localparam int ADDR_W  = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wb_cyc_i,
  input  logic                wb_stb_i,
  input  logic                wb_we_i,
  input  logic [1:0]          wb_adr_i,
  input  logic [31:0]         wb_dat_i,
  output logic [31:0]         wb_dat_o,
  output logic                wb_ack_o,
  input  logic                smp_en,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic [SAMPLE_W-1:0] out_data,
  output logic                out_valid,
  input  logic                out_ready
);
  cap_state_e        state;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  len;
  logic              start_cmd;
  logic              clear_cmd;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic              mem_re;
  logic [ADDR_W-1:0] mem_raddr;

  cap_regs #(.DEPTH(DEPTH)) u_regs (
    .clk(clk), .rst(rst),
    .cyc(wb_cyc_i), .stb(wb_stb_i), .we(wb_we_i), .adr(wb_adr_i),
    .wdat(wb_dat_i), .rdat(wb_dat_o), .ack(wb_ack_o),
    .state(state), .count(count), .len(len),
    .start_cmd(start_cmd), .clear_cmd(clear_cmd)
  );

  cap_seq #(.DEPTH(DEPTH)) u_seq (
    .clk(clk), .rst(rst),
    .start_cmd(start_cmd), .clear_cmd(clear_cmd), .len(len),
    .smp_en(smp_en), .out_ready(out_ready),
    .state(state), .count(count),
    .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_re(mem_re), .mem_raddr(mem_raddr),
    .out_valid(out_valid)
  );

  cap_mem #(.DATA_W(SAMPLE_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk),
    .we(mem_we), .waddr(mem_waddr), .wdata(smp_data),
    .re(mem_re), .raddr(mem_raddr), .rdata(out_data)
  );

  a_r7_data_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> $stable(out_data));
  a_r5_write_only_capturing: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (state == ST_CAPTURE));
endmodule

// File: tb/cap_buffer_tb.sv
module cap_buffer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TB_DEPTH   = 16;
  localparam int SW         = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wb_cyc_i = 1'b0, wb_stb_i = 1'b0, wb_we_i = 1'b0;
  logic [1:0]    wb_adr_i = '0;
  logic [31:0]   wb_dat_i = '0;
  logic [31:0]   wb_dat_o;
  logic          wb_ack_o;
  logic          smp_en = 1'b0;
  logic [SW-1:0] smp_data = '0;
  logic [SW-1:0] out_data;
  logic          out_valid;
  logic          out_ready = 1'b0;

  int n_checks = 0;
  int n_fails  = 0;
  logic [SW-1:0] exp_q [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_buffer #(.SAMPLE_W(SW), .DEPTH(TB_DEPTH)) u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wb_access(input bit wr, input logic [1:0] a, input logic [31:0] d,
                           output logic [31:0] rd);
    @(negedge clk);
    wb_cyc_i = 1'b1; wb_stb_i = 1'b1; wb_we_i = wr; wb_adr_i = a; wb_dat_i = d;
    @(negedge clk);
    check(wb_ack_o == 1'b1, "R2 ack one clock after strobe", int'(wb_ack_o), 1);
    rd = wb_dat_o;
    wb_cyc_i = 1'b0; wb_stb_i = 1'b0; wb_we_i = 1'b0;
    @(negedge clk);
    check(wb_ack_o == 1'b0, "R2 ack single cycle", int'(wb_ack_o), 0);
  endtask

  task automatic wb_write(input logic [1:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    wb_access(1'b1, a, d, dummy);
  endtask

  task automatic read_status(output logic [31:0] s);
    wb_access(1'b0, 2'd3, '0, s);
  endtask

  task automatic feed(input int n, input int first, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_en   = 1'b1;
      smp_data = SW'(seed * 37 + i * 11 + 5);
      if (first >= 0) exp_q[first + i] = smp_data;
    end
    @(negedge clk);
    smp_en = 1'b0;
  endtask

  task automatic drain(input int n, input bit stall, input string req);
    int t;
    t = 0;
    while (!out_valid && t < 50) begin @(negedge clk); t++; end
    for (int i = 0; i < n; i++) begin
      check(out_valid == 1'b1, stall ? "R6 word present" : "R11 no gap", int'(out_valid), 1);
      check(out_data == exp_q[n-1-i], req, int'(out_data), int'(exp_q[n-1-i]));
      if (stall) begin
        out_ready = 1'b0;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b1, "R7 valid held in stall", int'(out_valid), 1);
        check(out_data == exp_q[n-1-i], "R7 data held in stall", int'(out_data), int'(exp_q[n-1-i]));
      end
      out_ready = 1'b1;
      @(negedge clk);
      if (stall) begin
        out_ready = 1'b0;
        if (i < n-1) begin
          t = 0;
          while (!out_valid && t < 10) begin @(negedge clk); t++; end
        end
      end
    end
    out_ready = 1'b0;
    check(out_valid == 1'b0, "R8 valid low after address 0", int'(out_valid), 0);
  endtask

  task automatic t_reset;
    logic [31:0] s;
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(wb_ack_o == 1'b0, "R1 ack after reset", int'(wb_ack_o), 0);
    read_status(s);
    check(s == 32'd0, "R1 status after reset", int'(s), 0);
  endtask

  task automatic t_length;
    logic [31:0] r;
    wb_write(2'd0, 32'd1000);
    wb_access(1'b0, 2'd0, '0, r);
    check(r == 32'(TB_DEPTH), "R3 length clamped", int'(r), TB_DEPTH);
    wb_write(2'd0, 32'd7);
    wb_access(1'b0, 2'd0, '0, r);
    check(r == 32'd7, "R3 length readback", int'(r), 7);
    wb_write(2'd0, 32'd0);
    wb_write(2'd1, 32'd1);
    feed(3, -1, 9);
    read_status(r);
    check(r == 32'd0, "R3 start ignored with zero length", int'(r), 0);
    check(out_valid == 1'b0, "R3 no readout with zero length", int'(out_valid), 0);
  endtask

  task automatic t_basic;
    logic [31:0] s;
    wb_write(2'd0, 32'd5);
    wb_write(2'd1, 32'd1);
    read_status(s);
    check(s == 32'h2, "R4 busy during capture", int'(s), 2);
    feed(5, 0, 1);
    feed(3, -1, 77);   // strobes after capture ended
    drain(5, 1'b1, "R5 R6 reverse order, extra samples not stored");
    read_status(s);
    check(s == ((32'd5 << 16) | 32'h1), "R8 done and count", int'(s), int'((32'd5 << 16) | 32'h1));
    wb_write(2'd1, 32'd1);
    read_status(s);
    check(s[0] == 1'b1, "R10 start in done ignored", int'(s[0]), 1);
    wb_write(2'd2, 32'd1);
    read_status(s);
    check(s == 32'd0, "R10 clear returns to idle", int'(s), 0);
  endtask

  task automatic t_midrun;
    logic [31:0] s;
    wb_write(2'd0, 32'd4);
    wb_write(2'd1, 32'd1);
    feed(2, 0, 3);
    wb_write(2'd1, 32'd1);
    wb_write(2'd0, 32'd9);
    wb_write(2'd2, 32'd1);
    read_status(s);
    check(s == ((32'd2 << 16) | 32'h2), "R9 start mid-capture ignored", int'(s), int'((32'd2 << 16) | 32'h2));
    feed(2, 2, 4);
    feed(2, -1, 55);
    wb_write(2'd2, 32'd1);
    read_status(s);
    check(s == ((32'd4 << 16) | 32'h2), "R10 clear in readout ignored", int'(s), int'((32'd4 << 16) | 32'h2));
    drain(4, 1'b0, "R9 run keeps original length");
    read_status(s);
    check(s == ((32'd4 << 16) | 32'h1), "R9 count matches original length", int'(s), int'((32'd4 << 16) | 32'h1));
    wb_write(2'd2, 32'd1);
  endtask

  task automatic t_full;
    logic [31:0] s;
    wb_write(2'd0, 32'(TB_DEPTH));
    wb_write(2'd1, 32'd1);
    feed(TB_DEPTH, 0, 6);
    drain(TB_DEPTH, 1'b0, "R11 full depth streamed newest first");
    read_status(s);
    check(s == ((32'(TB_DEPTH) << 16) | 32'h1), "R8 full-depth count", int'(s), int'((32'(TB_DEPTH) << 16) | 32'h1));
    wb_write(2'd2, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_length();
    t_basic();
    t_midrun();
    t_full();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule